// File: doc/BRIEF.md
# Parallel DAC Bus Write Sequencer

This block sits on the host side of an eight-channel converter that has a parallel write port. It takes one request at a time over a valid/ready handshake. Each request carries a 3-bit channel number and a 14-bit code. The block turns the request into a bus cycle on the converter's pins. It drives the channel onto the address lines and the code onto the data bus, pulls chip select low, and pulses the write strobe low. The converter captures the word on the rising edge of the strobe. Each phase is held long enough to meet the converter's minimum setup, pulse-width and hold times.

A separate load request produces one active-low load pulse. That pulse makes the converter update all of its outputs together. If a load request arrives while a write is running, it waits and is issued once chip select has returned high.

All timing limits are given as parameters in picoseconds, together with the clock period. Each limit is converted to a whole number of clock cycles by rounding up, with a floor of one cycle. The block therefore stays correct when the system clock changes.

Top module: `dac_wr_seq`

## Requirements
- R1: During and immediately after reset, `dac_cs_n`, `dac_wr_n` and `dac_ld_n` are high and `req_ready` is high.
- R2: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the write sequence ends. With no load queued, `req_ready` is low for exactly SU+WR+1 cycles after the accepting edge, where SU and WR are defined in R4 and R5.
- R3: Chip select stays low for the whole write sequence. While it is low, `dac_addr` carries the accepted channel (channel n appears as the binary value n) and `dac_data` carries the accepted code (bit 13 is the MSB). Both stay stable. At the rising edge of the write strobe they equal the request.
- R4: Chip select falls with address and data already valid. The write strobe then stays high for SU = max(1, ceil(ADDR_SU_PS / CLK_PS)) cycles before it falls, which is 2 at a 10 ns clock.
- R5: The write strobe is low for exactly WR cycles. WR = max(1, ceil(WR_LOW_PS / CLK_PS), ceil(DATA_SU_PS / CLK_PS)), which is 5 at a 10 ns clock.
- R6: The write strobe is never low while chip select is high. Chip select rises exactly one cycle after the write strobe rises, so address and data are held through that cycle.
- R7: A new request is only accepted while chip select and the load strobe are high. Back-to-back writes therefore have at least one cycle with chip select high between them.
- R8: Each load request produces one `dac_ld_n` low pulse of exactly LD = max(1, ceil(LD_LOW_PS / CLK_PS)) cycles, which is 5 at a 10 ns clock.
- R9: A load request that arrives during a write is queued. Its pulse starts only after chip select has risen, and `dac_ld_n` is never low while `dac_cs_n` is low. A queued load is issued before a waiting write.
- R10: Several load requests that arrive while a load is already queued produce only one load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a write request |
| req_chan | input | 3 | Channel number of the request |
| req_code | input | 14 | Converter code of the request |
| ld_req | input | 1 | One-cycle request for a load pulse |
| dac_addr | output | 3 | Channel address lines to the converter |
| dac_data | output | 14 | Data bus to the converter |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_wr_n | output | 1 | Write strobe, active low |
| dac_ld_n | output | 1 | Update-all load strobe, active low |

## Verification
Writes are issued with all-zero and all-one codes on the lowest and highest channel numbers. They are also issued with the adjacent codes 0x1FFF and 0x2000, which differ in every bit. A wrong bit lane, a swapped channel or a stale bus value therefore shows up in the scoreboard. A back-to-back chain of writes separates a design that keeps the idle cycle with chip select high from one that runs writes together. Load requests are sent in three situations: while the bus is idle, once during a write, and twice during one write. These cases show whether a load is queued, whether it overlaps chip select, and whether repeated requests merge into one pulse.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_LOAD   = 3'd4
  } seq_state_t;

  // Round a time limit up to whole clock cycles, never below one.
  function automatic int ps_to_cycles(input int limit_ps, input int period_ps);
    int c;
    c = (limit_ps + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_width(input int max_count);
    return (max_count < 2) ? 1 : $clog2(max_count + 1);
  endfunction

endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dac_load_queue.sv
module dac_load_queue (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_req,
  input  logic issue,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= ld_req | (pending & ~issue);
  end
endmodule

// File: rtl/dac_bus_latch.sv
module dac_bus_latch #(
  parameter int CHAN_W = 3,
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [CHAN_W-1:0] addr_out,
  output logic [CODE_W-1:0] data_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out <= '0;
      data_out <= '0;
    end else if (capture) begin
      addr_out <= chan_in;
      data_out <= code_in;
    end
  end
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_wr_pkg::*;
#(
  parameter int CHAN_W     = 3,
  parameter int CODE_W     = 14,
  parameter int CLK_PS     = 10000,
  parameter int ADDR_SU_PS = 15000,
  parameter int WR_LOW_PS  = 50000,
  parameter int DATA_SU_PS = 20000,
  parameter int LD_LOW_PS  = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [CODE_W-1:0] req_code,
  input  logic              ld_req,
  output logic [CHAN_W-1:0] dac_addr,
  output logic [CODE_W-1:0] dac_data,
  output logic              dac_cs_n,
  output logic              dac_wr_n,
  output logic              dac_ld_n
);
  localparam int SU_CYC  = ps_to_cycles(ADDR_SU_PS, CLK_PS);
  localparam int WR_CYC  = max_of(ps_to_cycles(WR_LOW_PS, CLK_PS),
                                  ps_to_cycles(DATA_SU_PS, CLK_PS));
  localparam int LD_CYC  = ps_to_cycles(LD_LOW_PS, CLK_PS);
  localparam int MAX_CYC = max_of(max_of(SU_CYC, WR_CYC), LD_CYC);
  localparam int CNT_W   = cnt_width(MAX_CYC);

  seq_state_t       state, state_nx;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             ld_pend;

  // Named internal events
  logic accept, ld_issue, strobe_end, in_write;

  assign in_write   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign req_ready  = (state == ST_IDLE) && !ld_pend;
  assign accept     = req_valid && req_ready;
  assign ld_issue   = (state == ST_IDLE) && ld_pend;
  assign strobe_end = (state == ST_STROBE) && tmr_done;

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (ld_pend) begin
          state_nx = ST_LOAD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(LD_CYC - 1);
        end else if (req_valid) begin
          state_nx = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SU_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (tmr_done) begin
          state_nx = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WR_CYC - 1);
        end
      end
      ST_STROBE: if (tmr_done) state_nx = ST_HOLD;
      ST_HOLD:   state_nx = ST_IDLE;
      ST_LOAD:   if (tmr_done) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  dac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  dac_load_queue u_ldq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_req  (ld_req),
    .issue   (ld_issue),
    .pending (ld_pend)
  );

  dac_bus_latch #(.CHAN_W(CHAN_W), .CODE_W(CODE_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .chan_in  (req_chan),
    .code_in  (req_code),
    .addr_out (dac_addr),
    .data_out (dac_data)
  );

  assign dac_cs_n = !in_write;
  assign dac_wr_n = (state != ST_STROBE);
  assign dac_ld_n = (state != ST_LOAD);

endmodule

// File: rtl/dac_wr_seq_chk.sv
module dac_wr_seq_chk #(
  parameter int CHAN_W = 3,
  parameter int CODE_W = 14,
  parameter int SU_CYC = 2,
  parameter int WR_CYC = 5,
  parameter int LD_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CHAN_W-1:0] dac_addr,
  input logic [CODE_W-1:0] dac_data,
  input logic              dac_cs_n,
  input logic              dac_wr_n,
  input logic              dac_ld_n
);
  logic        wr_q, cs_q, ld_q;
  logic [15:0] wr_run, su_run, ld_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1; cs_q <= 1'b1; ld_q <= 1'b1;
      wr_run <= '0; su_run <= '0; ld_run <= '0;
    end else begin
      wr_q <= dac_wr_n; cs_q <= dac_cs_n; ld_q <= dac_ld_n;
      wr_run <= dac_wr_n ? 16'd0 : wr_run + 16'd1;
      ld_run <= dac_ld_n ? 16'd0 : ld_run + 16'd1;
      su_run <= dac_cs_n ? 16'd0 : (dac_wr_n ? su_run + 16'd1 : su_run);
    end
  end

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> !req_ready);
  p_bus_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n && !cs_q) |-> ($stable(dac_addr) && $stable(dac_data)));
  p_addr_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_wr_n && wr_q) |-> (su_run == 16'(SU_CYC)));
  p_wr_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr_n && !wr_q) |-> (wr_run == 16'(WR_CYC)));
  p_cs_frames_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> !dac_cs_n);
  p_cs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_cs_n && !cs_q) |-> wr_q);
  p_accept_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (dac_cs_n && dac_ld_n));
  p_ld_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_ld_n && !ld_q) |-> (ld_run == 16'(LD_CYC)));
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ld_n |-> dac_cs_n);
endmodule

bind dac_wr_seq dac_wr_seq_chk #(
  .CHAN_W (CHAN_W),
  .CODE_W (CODE_W),
  .SU_CYC (SU_CYC),
  .WR_CYC (WR_CYC),
  .LD_CYC (LD_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .dac_addr  (dac_addr),
  .dac_data  (dac_data),
  .dac_cs_n  (dac_cs_n),
  .dac_wr_n  (dac_wr_n),
  .dac_ld_n  (dac_ld_n)
);

// File: tb/dac_wr_seq_bench.sv
`timescale 1ns/1ps
module dac_wr_seq_bench;
  localparam int CLK_PS = 10000;
  localparam int SU_EXP = (15000 + CLK_PS - 1) / CLK_PS;
  localparam int WR_A   = (50000 + CLK_PS - 1) / CLK_PS;
  localparam int WR_B   = (20000 + CLK_PS - 1) / CLK_PS;
  localparam int WR_EXP = (WR_A > WR_B) ? WR_A : WR_B;
  localparam int LD_EXP = (50000 + CLK_PS - 1) / CLK_PS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_chan = '0;
  logic [13:0] req_code = '0;
  logic        ld_req = 1'b0;
  logic [2:0]  dac_addr;
  logic [13:0] dac_data;
  logic        dac_cs_n, dac_wr_n, dac_ld_n;

  int n_chk = 0, n_fail = 0;
  int ld_pulses = 0;
  bit finished = 1'b0;
  logic [16:0] exp_q[$];

  always #5 clk = ~clk;

  dac_wr_seq u_dac_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_code(req_code), .ld_req(ld_req),
    .dac_addr(dac_addr), .dac_data(dac_data), .dac_cs_n(dac_cs_n),
    .dac_wr_n(dac_wr_n), .dac_ld_n(dac_ld_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: samples once per cycle at the falling edge
  bit prev_wr = 1, prev_cs = 1, prev_ld = 1, mon_on = 0;
  int wr_run = 0, su_run = 0, ld_run = 0, hi_run = 0, since_wr_rise = 99;
  always @(negedge clk) if (mon_on) begin
    if (!dac_wr_n && dac_cs_n) check(0, "R6 wr low with cs high", 1, 0);
    if (!dac_ld_n && !dac_cs_n) check(0, "R9 load overlaps cs", 1, 0);
    if (!dac_wr_n && prev_wr) check(su_run == SU_EXP, "R4 setup cycles", su_run, SU_EXP);
    if (dac_wr_n && !prev_wr) begin
      logic [16:0] e;
      check(wr_run == WR_EXP, "R5 strobe width", wr_run, WR_EXP);
      check(!dac_cs_n, "R6 cs held at strobe rise", dac_cs_n, 0);
      if (exp_q.size() == 0) check(0, "R3 unexpected write", {dac_addr, dac_data}, 0);
      else begin
        e = exp_q.pop_front();
        check({dac_addr, dac_data} == e, "R3 bus word", {dac_addr, dac_data}, e);
      end
      since_wr_rise = 0;
    end else if (since_wr_rise < 99) since_wr_rise++;
    if (dac_cs_n && !prev_cs) check(since_wr_rise == 1, "R6 cs rise one cycle after strobe", since_wr_rise, 1);
    if (!dac_cs_n && prev_cs) check(hi_run >= 1, "R7 idle gap", hi_run, 1);
    if (dac_ld_n && !prev_ld) begin
      check(ld_run == LD_EXP, "R8 load width", ld_run, LD_EXP);
      ld_pulses++;
    end
    wr_run = dac_wr_n ? 0 : wr_run + 1;
    ld_run = dac_ld_n ? 0 : ld_run + 1;
    hi_run = dac_cs_n ? hi_run + 1 : 0;
    su_run = dac_cs_n ? 0 : (dac_wr_n ? su_run + 1 : su_run);
    prev_wr = dac_wr_n; prev_cs = dac_cs_n; prev_ld = dac_ld_n;
  end

  // Driver: called just after a falling edge; returns at a falling edge
  task automatic write(input logic [2:0] ch, input logic [13:0] code, input bit chk_lat);
    int n;
    req_chan = ch; req_code = code; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back({ch, code});
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!req_ready) begin n++; @(negedge clk); end
    if (chk_lat) check(n == SU_EXP + WR_EXP + 1, "R2 ready low cycles", n, SU_EXP + WR_EXP + 1);
  endtask

  task automatic pulse_ld();
    ld_req = 1'b1; @(negedge clk); ld_req = 1'b0;
  endtask

  task automatic wait_idle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dac_cs_n && dac_wr_n && dac_ld_n, "R1 strobes high in reset", {dac_cs_n, dac_wr_n, dac_ld_n}, 7);
    check(req_ready, "R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(dac_cs_n && dac_wr_n && dac_ld_n && req_ready, "R1 after reset",
          {dac_cs_n, dac_wr_n, dac_ld_n, req_ready}, 15);
    mon_on = 1;

    // R2 R3 R4 R5 R6: single writes with boundary patterns
    write(3'd0, 14'h0000, 1);
    wait_idle(3);
    write(3'd7, 14'h3FFF, 1);
    wait_idle(2);
    write(3'd3, 14'h1FFF, 1);
    write(3'd4, 14'h2000, 1);   // R7 back-to-back
    write(3'd5, 14'h2AAA, 1);
    write(3'd2, 14'h1555, 1);
    wait_idle(4);
    check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);

    // R8: load in idle
    base = ld_pulses;
    pulse_ld();
    check(!req_ready, "R9 ready low while load queued", req_ready, 0);
    wait_idle(LD_EXP + 3);
    check(ld_pulses == base + 1, "R8 one idle load pulse", ld_pulses - base, 1);

    // R9: load during a write is queued
    base = ld_pulses;
    fork
      write(3'd6, 14'h0F0F, 0);
      begin wait_idle(3); pulse_ld(); end
    join
    wait_idle(LD_EXP + 4);
    check(ld_pulses == base + 1, "R9 queued load issued", ld_pulses - base, 1);

    // R10: two requests during one write merge
    base = ld_pulses;
    fork
      write(3'd1, 14'h3001, 0);
      begin wait_idle(2); pulse_ld(); wait_idle(1); pulse_ld(); end
    join
    wait_idle(LD_EXP + 4);
    check(ld_pulses == base + 1, "R10 merged load", ld_pulses - base, 1);

    // R9: queued load goes before a waiting write
    base = ld_pulses;
    pulse_ld();
    write(3'd7, 14'h0001, 0);
    check(ld_pulses == base + 1, "R9 load before waiting write", ld_pulses - base, 1);
    wait_idle(4);
    check(exp_q.size() == 0, "R3 final queue empty", exp_q.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule